// File: doc/BRIEF.md
# Six-Channel Programmable Interval Timer

This block holds a bank of identical timer channels behind a 32-bit word-addressed register bus. Each channel has its own 16-byte window with four words: a target value, a live count, a control word and an interrupt word. A running channel advances its count once every N clock cycles, where N is a programmable divisor. When the count is about to reach the target, the channel raises its pending flag and returns the count to zero. It then either halts (one-shot) or keeps running (periodic).

Software uses one-shot mode to schedule single events and periodic mode for a fixed tick. With a target at the 28-bit maximum, a channel becomes a free-running time base whose count software reads directly. Each channel drives one interrupt line, which is asserted while the channel's pending flag and its interrupt enable are both set.

Inside each channel a two-state machine controls counting. State `ST_IDLE` means stopped and `ST_RUN` means counting. The transitions are:
- *start*: `ST_IDLE` to `ST_RUN`, on a control write with the enable bit set.
- *stop*: `ST_RUN` to `ST_IDLE`, on a control write with the enable bit clear.
- *expire*: `ST_RUN` to `ST_IDLE`, on a one-shot match.
- *reload*: `ST_RUN` to `ST_RUN`, on a periodic match.
- *hold*: a state stays as it is when none of the above applies.

Top module: `tmr_bank`

## Requirements
- R1: Channel k (k = 0..5) occupies byte addresses 0x10*k to 0x10*k+0xF. Within a channel the words are: target at offset 0x0, count at 0x4, control at 0x8, interrupt at 0xC. Address bits [1:0] are ignored.
- R2: Target and count are 28 bits wide. A write keeps bits [27:0], and bits [31:28] read as zero, so 0x0FFFFFFF is the largest period.
- R3: In the control word, bit 28 is enable, bit 24 selects periodic (1) or one-shot (0), and bits [15:0] hold the divisor. Bit 28 reads 1 while the channel runs. A write that sets enable on a stopped channel starts it with a fresh prescaler.
- R4: A running channel increments its count every D cycles, where D is the divisor, or 2 when the divisor is below 2. With count 0 at the enabling write edge, the count equals k at edge k*D after it, and the count is readable at any time.
- R5: A match occurs on the increment that would make the count equal the target. The match sets pending and loads the count with 0, so the first match comes T*D edges after the enabling write (T is the target).
- R6: In one-shot mode a match stops the channel, and control bit 28 then reads 0.
- R7: In periodic mode a match leaves the channel running, and the next match follows T*D edges later.
- R8: In the interrupt word, bit 20 is the interrupt enable and bit 16 is pending. Writing 1 to bit 16 clears pending and writing 0 leaves it unchanged. A match in the same cycle as a clear leaves pending set.
- R9: A channel's interrupt output is high exactly when its pending flag and interrupt enable are both 1. Pending stays set after the channel is stopped.
- R10: A write to the count register loads the count and restarts the prescaler. A control write with bit 28 clear stops counting.
- R11: Reads return zero in unused bits and at addresses beyond the last channel. Writes to those addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, qualified by bus_sel |
| bus_addr | input | AW (8) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | NCH (6) | One interrupt line per channel |

## Verification
The assertions assume that a write lasts one cycle with bus_sel and bus_we both high, and that bus_addr is a defined value whenever reset is released. The bench meets this by driving the bus only on falling edges, with one-cycle write pulses, and by holding the address at zero between accesses.

The tick-spacing property relies on the rule that a divisor below 2 acts as 2. The bench therefore programs divisors of 0 and 1 alongside larger values. It also changes the divisor only while a channel is stopped, so the comparison against a smaller divisor is never exercised in the middle of a period.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int EN_BIT   = 28;
    localparam int MODE_BIT = 24;
    localparam int IE_BIT   = 20;
    localparam int PEND_BIT = 16;

    localparam logic [1:0] REG_TGT  = 2'd0;
    localparam logic [1:0] REG_CNT  = 2'd1;
    localparam logic [1:0] REG_CTRL = 2'd2;
    localparam logic [1:0] REG_INT  = 2'd3;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } tmr_state_e;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] div_eff;
    logic [DIV_W-1:0] pre_q;

    // divisor values 0 and 1 behave as 2
    assign div_eff = (div < DIV_W'(2)) ? DIV_W'(2) : div;
    assign tick    = run && !restart && (pre_q >= div_eff - DIV_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart || tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 28,
    parameter int DIV_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_reg,
    input  logic [31:0] wr_data,
    input  logic [1:0]  rd_reg,
    output logic [31:0] rd_data,
    output logic        irq,
    output logic        tick,
    output logic        match,
    output logic        run,
    output logic        pend,
    output logic        periodic
);
    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] target_q, cnt_q, cnt_nxt;
    logic [DIV_W-1:0] div_q;
    logic             mode_q, ie_q, pend_q;
    logic             wr_tgt, wr_cnt, wr_ctrl, wr_int;
    logic             unused_wd;

    assign unused_wd = ^wr_data;
    assign wr_tgt    = wr_en && (wr_reg == REG_TGT);
    assign wr_cnt    = wr_en && (wr_reg == REG_CNT);
    assign wr_ctrl   = wr_en && (wr_reg == REG_CTRL);
    assign wr_int    = wr_en && (wr_reg == REG_INT);

    tmr_prescale #(.DIV_W(DIV_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (wr_cnt),
        .div     (div_q),
        .tick    (tick)
    );

    assign cnt_nxt = cnt_q + CNT_W'(1);
    assign match   = tick && !wr_cnt && (cnt_nxt == target_q);

    // next-state logic: start, stop, expire, reload, hold
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (wr_ctrl && wr_data[EN_BIT]) state_d = ST_RUN;
            ST_RUN: begin
                if (wr_ctrl)              state_d = wr_data[EN_BIT] ? ST_RUN : ST_IDLE;
                else if (match && !mode_q) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs of the state machine
    always_comb begin
        run      = (state_q == ST_RUN);
        pend     = pend_q;
        periodic = mode_q;
        irq      = pend_q && ie_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target_q <= '0;
            cnt_q    <= '0;
            div_q    <= '0;
            mode_q   <= 1'b0;
            ie_q     <= 1'b0;
            pend_q   <= 1'b0;
        end else begin
            if (wr_tgt) target_q <= wr_data[CNT_W-1:0];
            if (wr_cnt)      cnt_q <= wr_data[CNT_W-1:0];
            else if (match)  cnt_q <= '0;
            else if (tick)   cnt_q <= cnt_nxt;
            if (wr_ctrl) begin
                mode_q <= wr_data[MODE_BIT];
                div_q  <= wr_data[DIV_W-1:0];
            end
            if (wr_int) ie_q <= wr_data[IE_BIT];
            if (match)                          pend_q <= 1'b1;
            else if (wr_int && wr_data[PEND_BIT]) pend_q <= 1'b0;
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_reg)
            REG_TGT:  rd_data[CNT_W-1:0] = target_q;
            REG_CNT:  rd_data[CNT_W-1:0] = cnt_q;
            REG_CTRL: begin
                rd_data[EN_BIT]    = run;
                rd_data[MODE_BIT]  = mode_q;
                rd_data[DIV_W-1:0] = div_q;
            end
            REG_INT: begin
                rd_data[IE_BIT]   = ie_q;
                rd_data[PEND_BIT] = pend_q;
            end
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank #(
    parameter int NCH   = 6,
    parameter int AW    = 8,
    parameter int CNT_W = 28,
    parameter int DIV_W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_sel,
    input  logic           bus_we,
    input  logic [AW-1:0]  bus_addr,
    input  logic [31:0]    bus_wdata,
    output logic [31:0]    bus_rdata,
    output logic [NCH-1:0] irq
);
    localparam int CH_W = AW - 4;

    logic [CH_W-1:0] ch_sel;
    logic [1:0]      reg_sel;
    logic [NCH-1:0]  ch_wr, ch_tick, ch_match, ch_run, ch_pend, ch_mode;
    logic [31:0]     ch_rd [NCH];
    logic            unused_lsb;

    assign ch_sel     = bus_addr[AW-1:4];
    assign reg_sel    = bus_addr[3:2];
    assign unused_lsb = ^bus_addr[1:0];

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign ch_wr[g] = bus_sel && bus_we && (ch_sel == CH_W'(g));
        tmr_channel #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (ch_wr[g]),
            .wr_reg   (reg_sel),
            .wr_data  (bus_wdata),
            .rd_reg   (reg_sel),
            .rd_data  (ch_rd[g]),
            .irq      (irq[g]),
            .tick     (ch_tick[g]),
            .match    (ch_match[g]),
            .run      (ch_run[g]),
            .pend     (ch_pend[g]),
            .periodic (ch_mode[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (ch_sel == CH_W'(i)) bus_rdata = ch_rd[i];
        end
    end
endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk #(
    parameter int NCH = 6,
    parameter int AW  = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bus_sel,
    input logic           bus_we,
    input logic [AW-1:0]  bus_addr,
    input logic [31:0]    bus_wdata,
    input logic [31:0]    bus_rdata,
    input logic [NCH-1:0] ch_wr,
    input logic [NCH-1:0] ch_tick,
    input logic [NCH-1:0] ch_match,
    input logic [NCH-1:0] ch_run,
    input logic [NCH-1:0] ch_pend,
    input logic [NCH-1:0] ch_mode
);
    // R11
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(bus_addr[AW-1:4]) >= NCH) |-> (bus_rdata == 32'h0));

    // R1
    single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we) |-> $onehot0(ch_wr));

    for (genvar g = 0; g < NCH; g++) begin : g_prop
        // R4
        tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ch_tick[g] |=> !ch_tick[g]);

        // R5
        match_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ch_match[g] |=> ch_pend[g]);

        // R6
        oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_match[g] && !ch_mode[g] && !ch_wr[g]) |=> !ch_run[g]);

        // R7
        periodic_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_match[g] && ch_mode[g] && !ch_wr[g]) |=> ch_run[g]);

        // R8
        pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(ch_pend[g]) |-> $past(ch_wr[g] && bus_wdata[16]));
    end
endmodule

bind tmr_bank tmr_bank_chk #(.NCH(NCH), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ch_wr     (ch_wr),
    .ch_tick   (ch_tick),
    .ch_match  (ch_match),
    .ch_run    (ch_run),
    .ch_pend   (ch_pend),
    .ch_mode   (ch_mode)
);

// File: tb/tmr_bank_bench.sv
module tmr_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic [5:0]  irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tmr_bank u_tmr_bank (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // {divisor, target, expected edges to first match}
    localparam logic [47:0] VEC [6] = '{
        {16'd2, 16'd3, 16'd6},
        {16'd5, 16'd4, 16'd20},
        {16'd0, 16'd5, 16'd10},
        {16'd1, 16'd2, 16'd4},
        {16'd3, 16'd1, 16'd3},
        {16'd7, 16'd3, 16'd21}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic bwr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_we = 1'b0; bus_addr = 8'h0;
    endtask

    task automatic brd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
        bus_addr = 8'h0;
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            failures++;
            $display("FAIL R4 watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk("R9 reset irq", {26'h0, irq}, 32'h0);
        brd(8'h08, rd); chk("R3 reset ctrl", rd, 32'h0);
        brd(8'h54, rd); chk("R2 reset count", rd, 32'h0);
        brd(8'h5C, rd); chk("R8 reset int", rd, 32'h0);

        // vector walk: one-shot match on each channel in turn
        for (int i = 0; i < 6; i++) begin
            logic [15:0] dv, tg, ex;
            logic [7:0]  base;
            {dv, tg, ex} = VEC[i];
            base = 8'(i * 16);
            bwr(base + 8'h0, {16'h0, tg});
            bwr(base + 8'h4, 32'h0);
            bwr(base + 8'hC, 32'h0011_0000);
            bwr(base + 8'h8, 32'h1000_0000 | {16'h0, dv});
            wait_edges(int'(ex) - 1);
            chk("R4 R1 before match", {26'h0, irq}, 32'((1 << i) - 1));
            wait_edges(1);
            chk("R5 R1 at match", {26'h0, irq}, 32'((1 << (i + 1)) - 1));
            brd(base + 8'h4, rd); chk("R5 count zero", rd, 32'h0);
            brd(base + 8'h8, rd); chk("R6 enable cleared", rd, {16'h0, dv});
        end

        // clear every pending flag
        for (int i = 0; i < 6; i++) bwr(8'(i * 16) + 8'hC, 32'h0001_0000);
        @(negedge clk);
        chk("R8 clear all", {26'h0, irq}, 32'h0);

        // periodic on channel 2
        bwr(8'h20, 32'd3);
        bwr(8'h24, 32'h0);
        bwr(8'h2C, 32'h0011_0000);
        bwr(8'h28, 32'h1100_0002);
        wait_edges(6);
        chk("R7 first match", {31'h0, irq[2]}, 32'h1);
        brd(8'h24, rd); chk("R7 count zero", rd, 32'h0);
        brd(8'h28, rd); chk("R7 still running", rd, 32'h1100_0002);
        bwr(8'h2C, 32'h0011_0000);
        wait_edges(3);
        chk("R7 cleared before second", {31'h0, irq[2]}, 32'h0);
        wait_edges(1);
        chk("R7 second match", {31'h0, irq[2]}, 32'h1);
        bwr(8'h28, 32'h0);
        bwr(8'h2C, 32'h0001_0000);

        // time base and count write on channel 3
        bwr(8'h30, 32'h0FFF_FFFF);
        bwr(8'h34, 32'h0);
        bwr(8'h38, 32'h1000_0002);
        wait_edges(10);
        brd(8'h34, rd); chk("R4 time base", rd, 32'd5);
        bwr(8'h34, 32'h0);
        wait_edges(4);
        brd(8'h34, rd); chk("R10 count reload", rd, 32'd2);
        bwr(8'h38, 32'h0);
        wait_edges(6);
        brd(8'h34, rd); chk("R10 stopped", rd, 32'd3);

        // interrupt enable gating on channel 4
        bwr(8'h4C, 32'h0001_0000);
        bwr(8'h40, 32'd2);
        bwr(8'h44, 32'h0);
        bwr(8'h48, 32'h1000_0002);
        wait_edges(4);
        chk("R9 masked", {31'h0, irq[4]}, 32'h0);
        brd(8'h4C, rd); chk("R8 pending visible", rd, 32'h0001_0000);
        bwr(8'h4C, 32'h0010_0000);
        @(negedge clk);
        chk("R8 zero write keeps pending", {31'h0, irq[4]}, 32'h1);
        bwr(8'h48, 32'h0);
        @(negedge clk);
        chk("R9 persists when stopped", {31'h0, irq[4]}, 32'h1);
        bwr(8'h4C, 32'h0011_0000);
        @(negedge clk);
        chk("R8 w1c", {31'h0, irq[4]}, 32'h0);
        brd(8'h4C, rd); chk("R8 int readback", rd, 32'h0010_0000);

        // widths, unused bits, unmapped space on channel 1
        bwr(8'h10, 32'hFFFF_FFFF);
        brd(8'h10, rd); chk("R2 target width", rd, 32'h0FFF_FFFF);
        bwr(8'h64, 32'hFFFF_FFFF);
        bwr(8'h7C, 32'hFFFF_FFFF);
        brd(8'h64, rd); chk("R11 unmapped read", rd, 32'h0);
        brd(8'h10, rd); chk("R11 no alias", rd, 32'h0FFF_FFFF);
        brd(8'h14, rd); chk("R11 count untouched", rd, 32'h0);
        chk("R11 irq untouched", {26'h0, irq}, 32'h0);
        bwr(8'h18, 32'h0F0F_0003);
        brd(8'h18, rd); chk("R3 R11 ctrl bits", rd, 32'h0100_0003);
        bwr(8'h1A, 32'h0);
        brd(8'h1B, rd); chk("R1 low address bits ignored", rd, 32'h0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule